// File: doc/BRIEF.md
# Video Frame Clipper

This block cuts a rectangular region out of every video frame that passes through it. Pixels arrive one per beat on a valid/ready stream. The stream carries a start-of-frame flag and flags for end-of-line and end-of-frame. Only the pixels that fall inside the region are forwarded, on an output stream of the same shape. The output flags are regenerated so that they describe the smaller image. The input frame width and height are supplied as run-time inputs.

A word-addressed memory-mapped slave holds the region and a run/stop control. The region is given as four values. A synthesis parameter selects how the right and bottom values are read: as distances from the image edges (window mode), or as a width and height (rectangle mode). A second parameter selects one of two address layouts. The region is latched into the engine on the start-of-frame beat. Software may therefore rewrite it at any time without disturbing the frame in flight. Clearing the run bit parks the engine at the next frame boundary, with input ready held low.

Top module: `frame_crop`

## Requirements
- R1: Register address 0 bit 0 is the run bit, and it resets to 0. While the run bit is 0, the end-of-frame beat that is accepted leaves `in_ready` low from the next cycle until 1 is written to the run bit. After reset, `in_ready` is low until the run bit is set.
- R2: Register address 1 bit 0 reads 1 from the start-of-frame beat that is accepted up to the accepted end-of-frame beat, and reads 0 between frames. Bits 31:1 always read 0.
- R3: `csr_wait` is always low. Every read returns data with `csr_rvalid` high exactly one cycle after `csr_read`. A read of any address other than 1 returns 0.
- R4: In a write, byte lane n covers `csr_wdata[8n+7:8n]`. A lane whose `csr_be[n]` is 0 leaves its register bits unchanged.
- R5: The region registers and the image size are captured on the start-of-frame beat that is accepted. Writes made during a frame take effect only from the next frame.
- R6: In window mode (RECT_MODE=0) the pixel at column x, row y is kept when left ≤ x < W − right and top ≤ y < H − bottom. A value larger than the image size gives an empty range.
- R7: In rectangle mode (RECT_MODE=1) a pixel is kept when left ≤ x < min(left + width, W) and top ≤ y < min(top + height, H).
- R8: The layout is selected by ALT_MAP. With ALT_MAP=0, left, right/width, top and bottom/height sit at addresses 2, 3, 4 and 5. With ALT_MAP=1 they sit at 3, 4, 5 and 6, and a write to address 2 has no effect.
- R9: On the output, start-of-frame marks the first kept pixel, end-of-line marks the last kept pixel of each kept row, and end-of-frame marks the last kept pixel overall, together with end-of-line. Output data is the input pixel unchanged, and pixels keep their raster order.
- R10: When the region is empty, the whole frame is accepted and no output beat is produced.
- R11: While `out_valid` is high and `out_ready` is low, the output data and flags hold steady. No kept pixel is dropped or repeated under any pattern of backpressure.
- R12: Between frames, input beats that arrive without start-of-frame are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_write | input | 1 | Register write strobe |
| csr_read | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Word address |
| csr_wdata | input | BUS_W | Write data |
| csr_be | input | BUS_W/8 | Byte lane enables for writes |
| csr_rdata | output | BUS_W | Read data |
| csr_rvalid | output | 1 | Read data valid, one cycle after the read |
| csr_wait | output | 1 | Wait request, always low |
| img_w | input | DIM_W | Input frame width in pixels |
| img_h | input | DIM_W | Input frame height in pixels |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DATA_W | Input pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_eof | input | 1 | Last pixel of a frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DATA_W | Kept pixel |
| out_sof | output | 1 | First kept pixel |
| out_eol | output | 1 | Last kept pixel of a row |
| out_eof | output | 1 | Last kept pixel of the frame |

## Verification
The assertions rely on well-formed frames. Each frame opens with a start-of-frame beat, every line holds exactly `img_w` beats and ends with end-of-line, and end-of-frame comes on the last beat of line `img_h` − 1. The assertions also assume that `img_w`/`img_h` are stable while the frame is in flight. The bench builds every frame from the width and height it drives, so these rules always hold. Its random region values stay between 0 and the image size. Off-frame beats are sent only on purpose, between frames, to exercise the discard rule.

// File: rtl/frame_crop_pkg.sv
package frame_crop_pkg;

  typedef enum logic [1:0] {
    ENG_HALT,
    ENG_ARMED,
    ENG_RUN
  } eng_state_e;

  typedef enum logic [2:0] {
    SL_CTRL,
    SL_STAT,
    SL_LEFT,
    SL_RIGHT,
    SL_TOP,
    SL_BOT,
    SL_NONE
  } slot_e;

  // Map a word address onto a register slot; alt shifts the region block up by one.
  function automatic slot_e decode_slot(input int unsigned a, input bit alt);
    int unsigned base;
    base = alt ? 3 : 2;
    if (a == 0)             return SL_CTRL;
    else if (a == 1)        return SL_STAT;
    else if (a == base)     return SL_LEFT;
    else if (a == base + 1) return SL_RIGHT;
    else if (a == base + 2) return SL_TOP;
    else if (a == base + 3) return SL_BOT;
    else                    return SL_NONE;
  endfunction

endpackage

// File: rtl/crop_csr.sv
module crop_csr
  import frame_crop_pkg::*;
#(
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DIM_W   = 12,
  parameter bit          ALT_MAP = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 write,
  input  logic                 read,
  input  logic [ADDR_W-1:0]    address,
  input  logic [BUS_W-1:0]     writedata,
  input  logic [BUS_W/8-1:0]   byteenable,
  input  logic                 busy,
  output logic [BUS_W-1:0]     readdata,
  output logic                 readdatavalid,
  output logic                 waitrequest,
  output logic                 go,
  output logic [DIM_W-1:0]     reg_left,
  output logic [DIM_W-1:0]     reg_right,
  output logic [DIM_W-1:0]     reg_top,
  output logic [DIM_W-1:0]     reg_bot
);

  localparam int unsigned BE_W = BUS_W / 8;

  slot_e slot;
  logic  unused_csr;

  assign slot        = decode_slot(32'(address), ALT_MAP);
  assign waitrequest = 1'b0;
  assign unused_csr  = ^{writedata[BUS_W-1:DIM_W], byteenable};

  // Byte-lane merge of one region register.
  function automatic logic [DIM_W-1:0] lane_merge(
    input logic [DIM_W-1:0] old_v,
    input logic [BUS_W-1:0] wd,
    input logic [BE_W-1:0]  be
  );
    logic [DIM_W-1:0] r;
    r = old_v;
    for (int i = 0; i < DIM_W; i++) begin
      if (be[i/8]) r[i] = wd[i];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      go            <= 1'b0;
      reg_left      <= '0;
      reg_right     <= '0;
      reg_top       <= '0;
      reg_bot       <= '0;
      readdata      <= '0;
      readdatavalid <= 1'b0;
    end else begin
      readdatavalid <= read;
      if (read && slot == SL_STAT) readdata <= {{(BUS_W-1){1'b0}}, busy};
      else                         readdata <= '0;
      if (write) begin
        unique case (slot)
          SL_CTRL:  if (byteenable[0]) go <= writedata[0];
          SL_LEFT:  reg_left  <= lane_merge(reg_left,  writedata, byteenable);
          SL_RIGHT: reg_right <= lane_merge(reg_right, writedata, byteenable);
          SL_TOP:   reg_top   <= lane_merge(reg_top,   writedata, byteenable);
          SL_BOT:   reg_bot   <= lane_merge(reg_bot,   writedata, byteenable);
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/crop_axis.sv
module crop_axis #(
  parameter int unsigned DIM_W     = 12,
  parameter bit          RECT_MODE = 1'b0
) (
  input  logic [DIM_W-1:0] start_v,
  input  logic [DIM_W-1:0] far_v,
  input  logic [DIM_W-1:0] extent,
  output logic [DIM_W:0]   lim_lo,
  output logic [DIM_W:0]   lim_hi
);

  localparam int unsigned EW = DIM_W + 1;

  logic [EW-1:0] s_e, f_e, x_e;

  assign s_e    = EW'(start_v);
  assign f_e    = EW'(far_v);
  assign x_e    = EW'(extent);
  assign lim_lo = s_e;

  generate
    if (RECT_MODE) begin : g_rect
      logic [EW-1:0] sum;
      assign sum    = s_e + f_e;
      assign lim_hi = (sum > x_e) ? x_e : sum;
    end else begin : g_window
      assign lim_hi = (f_e > x_e) ? '0 : (x_e - f_e);
    end
  endgenerate

endmodule

// File: rtl/crop_engine.sv
module crop_engine
  import frame_crop_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DIM_W:0]    lv_left,
  input  logic [DIM_W:0]    lv_right,
  input  logic [DIM_W:0]    lv_top,
  input  logic [DIM_W:0]    lv_bot,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eol,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eol,
  output logic              out_eof,
  output logic              busy
);

  localparam int unsigned EW = DIM_W + 1;

  eng_state_e        state;
  logic [DIM_W-1:0]  xq, yq, px, py;
  logic [EW-1:0]     sh_left, sh_right, sh_top, sh_bot;
  logic [EW-1:0]     u_left, u_right, u_top, u_bot;
  logic [EW-1:0]     pxe, pye;
  logic              slot_free, fire, take, keep, last_col, last_row;

  always_comb begin
    u_left    = (state == ENG_RUN) ? sh_left  : lv_left;
    u_right   = (state == ENG_RUN) ? sh_right : lv_right;
    u_top     = (state == ENG_RUN) ? sh_top   : lv_top;
    u_bot     = (state == ENG_RUN) ? sh_bot   : lv_bot;
    px        = (state == ENG_RUN) ? xq : '0;
    py        = (state == ENG_RUN) ? yq : '0;
    pxe       = EW'(px);
    pye       = EW'(py);
    slot_free = !out_valid || out_ready;
    in_ready  = (state != ENG_HALT) && slot_free;
    fire      = in_valid && in_ready;
    take      = fire && ((state == ENG_RUN) || in_sof);
    keep      = take && (pxe >= u_left) && (pxe < u_right)
                     && (pye >= u_top) && (pye < u_bot);
    last_col  = (pxe == u_right - EW'(1));
    last_row  = (pye == u_bot - EW'(1));
  end

  assign busy = (state == ENG_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_HALT;
      xq        <= '0;
      yq        <= '0;
      sh_left   <= '0;
      sh_right  <= '0;
      sh_top    <= '0;
      sh_bot    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      if (slot_free) begin
        out_valid <= keep;
        out_data  <= in_data;
        out_sof   <= (pxe == u_left) && (pye == u_top);
        out_eol   <= last_col;
        out_eof   <= last_col && last_row;
      end
      if (take) begin
        xq <= in_eol ? '0 : px + DIM_W'(1);
        yq <= in_eol ? py + DIM_W'(1) : py;
      end
      unique case (state)
        ENG_HALT: begin
          if (go) state <= ENG_ARMED;
        end
        ENG_ARMED: begin
          if (take) begin
            sh_left  <= lv_left;
            sh_right <= lv_right;
            sh_top   <= lv_top;
            sh_bot   <= lv_bot;
            if (in_eof) state <= go ? ENG_ARMED : ENG_HALT;
            else        state <= ENG_RUN;
          end
        end
        ENG_RUN: begin
          if (take && in_eof) state <= go ? ENG_ARMED : ENG_HALT;
        end
        default: state <= ENG_HALT;
      endcase
    end
  end

endmodule

// File: rtl/frame_crop.sv
module frame_crop
  import frame_crop_pkg::*;
#(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned DIM_W     = 12,
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter bit          RECT_MODE = 1'b0,
  parameter bit          ALT_MAP   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csr_write,
  input  logic                 csr_read,
  input  logic [ADDR_W-1:0]    csr_addr,
  input  logic [BUS_W-1:0]     csr_wdata,
  input  logic [BUS_W/8-1:0]   csr_be,
  output logic [BUS_W-1:0]     csr_rdata,
  output logic                 csr_rvalid,
  output logic                 csr_wait,
  input  logic [DIM_W-1:0]     img_w,
  input  logic [DIM_W-1:0]     img_h,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_sof,
  input  logic                 in_eol,
  input  logic                 in_eof,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_sof,
  output logic                 out_eol,
  output logic                 out_eof
);

  logic              go_w, busy_w;
  logic [DIM_W-1:0]  r_left, r_right, r_top, r_bot;
  logic [DIM_W:0]    lim_l, lim_r, lim_t, lim_b;

  crop_csr #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W), .ALT_MAP(ALT_MAP)
  ) u_csr (
    .clk(clk), .rst(rst),
    .write(csr_write), .read(csr_read), .address(csr_addr),
    .writedata(csr_wdata), .byteenable(csr_be), .busy(busy_w),
    .readdata(csr_rdata), .readdatavalid(csr_rvalid), .waitrequest(csr_wait),
    .go(go_w), .reg_left(r_left), .reg_right(r_right),
    .reg_top(r_top), .reg_bot(r_bot)
  );

  crop_axis #(.DIM_W(DIM_W), .RECT_MODE(RECT_MODE)) u_cols (
    .start_v(r_left), .far_v(r_right), .extent(img_w),
    .lim_lo(lim_l), .lim_hi(lim_r)
  );

  crop_axis #(.DIM_W(DIM_W), .RECT_MODE(RECT_MODE)) u_rows (
    .start_v(r_top), .far_v(r_bot), .extent(img_h),
    .lim_lo(lim_t), .lim_hi(lim_b)
  );

  crop_engine #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_eng (
    .clk(clk), .rst(rst), .go(go_w),
    .lv_left(lim_l), .lv_right(lim_r), .lv_top(lim_t), .lv_bot(lim_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol), .out_eof(out_eof),
    .busy(busy_w)
  );

endmodule

// File: rtl/frame_crop_checker.sv
module frame_crop_checker #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              read,
  input logic              rvalid,
  input logic [BUS_W-1:0]  rdata,
  input logic [ADDR_W-1:0] address,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_eof,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sof,
  input logic              out_eol,
  input logic              out_eof,
  input logic              go,
  input logic              busy
);

  p_read_latency_r3: assert property (@(posedge clk) disable iff (rst)
    read |=> rvalid);

  p_no_stray_rvalid_r3: assert property (@(posedge clk) disable iff (rst)
    !read |=> !rvalid);

  p_other_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rvalid && ($past(address) != ADDR_W'(1)) |-> rdata == '0);

  p_status_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> rdata[BUS_W-1:1] == '0);

  p_status_tracks_busy_r2: assert property (@(posedge clk) disable iff (rst)
    rvalid && ($past(address) == ADDR_W'(1)) |-> rdata[0] == $past(busy));

  p_idle_after_eof_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_eof |=> !busy);

  p_halt_after_frame_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_eof && !go |=> !in_ready);

  p_hold_stalled_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                               && $stable({out_sof, out_eol, out_eof}));

  p_eof_with_eol_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eof |-> out_eol);

endmodule

bind frame_crop frame_crop_checker #(
  .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .read(csr_read), .rvalid(csr_rvalid),
  .rdata(csr_rdata), .address(csr_addr),
  .in_valid(in_valid), .in_ready(in_ready), .in_eof(in_eof),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eol(out_eol), .out_eof(out_eof),
  .go(go_w), .busy(busy_w)
);

// File: tb/frame_crop_test.sv
`timescale 1ns/1ps
module frame_crop_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        wr[2], rd[2], rvalid[2], wreq[2];
  logic [2:0]  addr[2];
  logic [31:0] wdata[2], rdata[2];
  logic [3:0]  be[2];
  logic [11:0] imw[2], imh[2];
  logic        in_valid[2], in_ready[2], in_sof[2], in_eol[2], in_eof[2];
  logic [23:0] in_data[2], out_data[2];
  logic        out_valid[2], out_ready[2], out_sof[2], out_eol[2], out_eof[2];
  logic        bp_en[2];

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [26:0] exp_q[$];
  logic [26:0] cap_q[$];

  frame_crop #(.RECT_MODE(1'b0), .ALT_MAP(1'b0)) uut (
    .clk(clk), .rst(rst),
    .csr_write(wr[0]), .csr_read(rd[0]), .csr_addr(addr[0]),
    .csr_wdata(wdata[0]), .csr_be(be[0]), .csr_rdata(rdata[0]),
    .csr_rvalid(rvalid[0]), .csr_wait(wreq[0]),
    .img_w(imw[0]), .img_h(imh[0]),
    .in_valid(in_valid[0]), .in_ready(in_ready[0]), .in_data(in_data[0]),
    .in_sof(in_sof[0]), .in_eol(in_eol[0]), .in_eof(in_eof[0]),
    .out_valid(out_valid[0]), .out_ready(out_ready[0]), .out_data(out_data[0]),
    .out_sof(out_sof[0]), .out_eol(out_eol[0]), .out_eof(out_eof[0])
  );

  frame_crop #(.RECT_MODE(1'b1), .ALT_MAP(1'b1)) uut_rect (
    .clk(clk), .rst(rst),
    .csr_write(wr[1]), .csr_read(rd[1]), .csr_addr(addr[1]),
    .csr_wdata(wdata[1]), .csr_be(be[1]), .csr_rdata(rdata[1]),
    .csr_rvalid(rvalid[1]), .csr_wait(wreq[1]),
    .img_w(imw[1]), .img_h(imh[1]),
    .in_valid(in_valid[1]), .in_ready(in_ready[1]), .in_data(in_data[1]),
    .in_sof(in_sof[1]), .in_eol(in_eol[1]), .in_eof(in_eof[1]),
    .out_valid(out_valid[1]), .out_ready(out_ready[1]), .out_data(out_data[1]),
    .out_sof(out_sof[1]), .out_eol(out_eol[1]), .out_eof(out_eof[1])
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Downstream readiness, random when enabled.
  initial begin
    forever begin
      @(posedge clk); #1;
      for (int k = 0; k < 2; k++)
        out_ready[k] = bp_en[k] ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // Output monitor: a beat seen valid&ready at the negedge transfers at the next edge.
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 2; k++)
        if (out_valid[k] && out_ready[k])
          cap_q.push_back({out_data[k], out_sof[k], out_eol[k], out_eof[k]});
    end
  end

  task automatic csr_wr(input int k, input int a, input logic [31:0] d, input logic [3:0] b);
    wr[k] = 1'b1; addr[k] = 3'(a); wdata[k] = d; be[k] = b;
    @(posedge clk); #1;
    wr[k] = 1'b0; be[k] = 4'h0;
  endtask

  task automatic csr_rd(input int k, input int a, output logic [31:0] d, output logic v);
    rd[k] = 1'b1; addr[k] = 3'(a);
    @(posedge clk); #1;
    rd[k] = 1'b0;
    @(negedge clk);
    d = rdata[k]; v = rvalid[k];
    @(posedge clk); #1;
  endtask

  function automatic int base_of(input int k);
    return (k == 1) ? 3 : 2;
  endfunction

  task automatic cfg(input int k, input int l, input int r, input int t, input int b);
    csr_wr(k, base_of(k),     32'(l), 4'hF);
    csr_wr(k, base_of(k) + 1, 32'(r), 4'hF);
    csr_wr(k, base_of(k) + 2, 32'(t), 4'hF);
    csr_wr(k, base_of(k) + 3, 32'(b), 4'hF);
  endtask

  task automatic beat(input int k, input logic [23:0] d, input bit s, input bit e, input bit f);
    bit acc;
    in_valid[k] = 1'b1; in_data[k] = d; in_sof[k] = s; in_eol[k] = e; in_eof[k] = f;
    do begin
      @(negedge clk); acc = in_ready[k];
      @(posedge clk); #1;
    end while (!acc);
    in_valid[k] = 1'b0; in_sof[k] = 1'b0; in_eol[k] = 1'b0; in_eof[k] = 1'b0;
  endtask

  task automatic send_frame(input int k, input int W, input int H, input int tag);
    imw[k] = 12'(W); imh[k] = 12'(H);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        beat(k, {8'(tag), 8'(y), 8'(x)}, (x == 0 && y == 0), (x == W - 1),
             (x == W - 1 && y == H - 1));
  endtask

  task automatic build_exp(input int k, input int l, input int r, input int t, input int b,
                           input int W, input int H, input int tag);
    int rl, bl;
    exp_q.delete();
    if (k == 1) begin
      rl = (l + r > W) ? W : l + r;
      bl = (t + b > H) ? H : t + b;
    end else begin
      rl = (r > W) ? 0 : W - r;
      bl = (b > H) ? 0 : H - b;
    end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        if (x >= l && x < rl && y >= t && y < bl)
          exp_q.push_back({8'(tag), 8'(y), 8'(x), 1'(x == l && y == t),
                           1'(x == rl - 1), 1'(x == rl - 1 && y == bl - 1)});
  endtask

  task automatic compare(input string req);
    int n;
    repeat (30) @(posedge clk);
    #1;
    chk(cap_q.size() == exp_q.size(), req, "output beat count", cap_q.size(), exp_q.size());
    n = (cap_q.size() < exp_q.size()) ? cap_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(cap_q[i] == exp_q[i], req, "beat {data,sof,eol,eof}", int'(cap_q[i]), int'(exp_q[i]));
    cap_q.delete();
  endtask

  task automatic run(input int k, input int l, input int r, input int t, input int b,
                     input int W, input int H, input int tag, input string req);
    cap_q.delete();
    build_exp(k, l, r, t, b, W, H, tag);
    send_frame(k, W, H, tag);
    compare(req);
  endtask

  initial begin
    logic [31:0] d;
    logic v;
    void'($urandom(32'd4242));
    for (int k = 0; k < 2; k++) begin
      wr[k] = 0; rd[k] = 0; addr[k] = 0; wdata[k] = 0; be[k] = 0;
      imw[k] = 12'd8; imh[k] = 12'd4; in_valid[k] = 0; in_data[k] = 0;
      in_sof[k] = 0; in_eol[k] = 0; in_eof[k] = 0; bp_en[k] = 0;
    end
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid[0] == 1'b0, "R9", "out_valid after reset", out_valid[0], 0);
    chk(in_ready[0] == 1'b0, "R1", "in_ready after reset", in_ready[0], 0);
    chk(wreq[0] == 1'b0, "R3", "wait request", wreq[0], 0);
    @(posedge clk); #1;

    csr_rd(0, 1, d, v);
    chk(v == 1'b1, "R3", "rvalid one cycle after read", v, 1);
    chk(d == 32'd0, "R2", "idle status", d, 0);
    csr_wr(0, 2, 32'd9, 4'hF);
    csr_rd(0, 2, d, v);
    chk(d == 32'd0 && v, "R3", "read of write-only address", d, 0);

    csr_wr(0, 0, 32'h1, 4'hF);
    csr_wr(1, 0, 32'h1, 4'hF);
    repeat (2) @(posedge clk); #1;

    // Window mode, directed.
    cfg(0, 2, 3, 1, 2);
    run(0, 2, 3, 1, 2, 10, 6, 1, "R6");
    // Single kept pixel in the corner: all three markers together.
    cfg(0, 9, 0, 5, 0);
    run(0, 9, 0, 5, 0, 10, 6, 2, "R9");
    // Empty region, then a normal frame.
    cfg(0, 5, 5, 0, 0);
    run(0, 5, 5, 0, 0, 10, 4, 3, "R10");
    cfg(0, 1, 1, 1, 1);
    run(0, 1, 1, 1, 1, 6, 4, 4, "R10");

    // Stray beats between frames are discarded.
    cap_q.delete();
    beat(0, 24'hEE0101, 0, 0, 0);
    beat(0, 24'hEE0102, 0, 1, 0);
    beat(0, 24'hEE0103, 0, 1, 1);
    run(0, 1, 1, 1, 1, 6, 4, 5, "R12");

    // Byte lanes: only lane 0 of left is written; an all-clear write changes nothing.
    cfg(0, 3, 1, 1, 1);
    csr_wr(0, 2, 32'h0000_0F07, 4'b0001);
    csr_wr(0, 2, 32'h0000_0000, 4'b0000);
    run(0, 7, 1, 1, 1, 12, 4, 6, "R4");

    // Shadowing: a mid-frame rewrite only affects the next frame.
    cfg(0, 1, 2, 0, 1);
    cap_q.delete();
    build_exp(0, 1, 2, 0, 1, 8, 5, 7);
    fork
      send_frame(0, 8, 5, 7);
      begin repeat (6) @(posedge clk); #1; cfg(0, 3, 0, 2, 0); end
    join
    compare("R5");
    run(0, 3, 0, 2, 0, 8, 5, 8, "R5");

    // Status during and after a frame.
    cap_q.delete();
    build_exp(0, 3, 0, 2, 0, 8, 4, 9);
    fork
      send_frame(0, 8, 4, 9);
      begin
        logic [31:0] sd; logic sv;
        repeat (10) @(posedge clk); #1;
        csr_rd(0, 1, sd, sv);
        chk(sd == 32'd1 && sv, "R2", "status mid-frame", sd, 1);
      end
    join
    compare("R2");
    csr_rd(0, 1, d, v);
    chk(d == 32'd0, "R2", "status between frames", d, 0);

    // Clearing the run bit parks the engine at the frame end.
    csr_wr(0, 0, 32'h0, 4'hF);
    run(0, 3, 0, 2, 0, 8, 4, 10, "R1");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready[0] == 1'b0, "R1", "in_ready while halted", in_ready[0], 0);
    @(posedge clk); #1;
    csr_wr(0, 0, 32'h1, 4'hF);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(in_ready[0] == 1'b1, "R1", "in_ready after restart", in_ready[0], 1);
    @(posedge clk); #1;

    // Rectangle mode on the shifted layout.
    cfg(1, 1, 4, 2, 3);
    run(1, 1, 4, 2, 3, 10, 8, 11, "R7");
    cfg(1, 4, 20, 6, 9);
    run(1, 4, 20, 6, 9, 10, 8, 12, "R7");
    csr_wr(1, 2, 32'h3, 4'hF);
    run(1, 4, 20, 6, 9, 10, 8, 13, "R8");

    // Random regions under random backpressure, both variants.
    for (int k = 0; k < 2; k++) begin
      bp_en[k] = 1'b1;
      for (int i = 0; i < 8; i++) begin
        int W, H, l, r, t, b;
        W = 4 + int'($urandom % 13); H = 2 + int'($urandom % 8);
        l = int'($urandom % (W + 1)); r = int'($urandom % (W + 1));
        t = int'($urandom % (H + 1)); b = int'($urandom % (H + 1));
        cfg(k, l, r, t, b);
        run(k, l, r, t, b, W, H, 20 + i + 10 * k, "R11");
      end
      bp_en[k] = 1'b0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule